// File: doc/BRIEF.md
# Programmable Word Fiber Test Generator

This block sits in the transmit data path, just before the serializer. It can replace live traffic with a test stimulus. While the enable input is low, the serial normal-data bit and its valid flag pass through one register stage unchanged. While the enable input is high, the output valid flag is held high and the output bit comes from one of two sources, picked by a select input. The first source is a programmable 16-bit word, sent most significant bit first and repeated back to back with no gap. The second is a constant logic-0 level with no transitions.

The programmed word is held in a shadow copy. The shadow copy is reloaded only at a word boundary, so a write to the pattern input never produces a partial word on the line. The bit position keeps counting while the enable is high, whichever source is selected. Switching between the two sources therefore keeps the word phase. The reset is asynchronous and active low. The block releases it internally in step with the clock.

Top module: `fiber_tpg`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released with enable low and valid-in low, tx_bit and tx_valid are 0.
- R2: While tp_enable is 1, tx_valid is 1 in the cycle after each clock edge at which tp_enable was sampled high.
- R3: With tp_enable = 1 and tp_use_word = 1, the pattern word goes out one bit per clock, bit 15 first and bit 0 last. The output then continues at bit 15 of the next word in the following cycle, with no idle cycle in between.
- R4: With tp_enable = 1 and tp_use_word = 0, tx_bit is constant logic 0.
- R5: With tp_enable = 0, tx_bit and tx_valid equal nd_bit and nd_valid as sampled at the previous clock edge (one cycle of latency).
- R6: A change to tp_word while the generator runs takes effect only at the next word boundary. The word currently being sent finishes with its old value.
- R7: Whenever tp_enable is low, the bit position returns to 15 and the shadow word follows tp_word. The first transmitted bit after enabling is therefore bit 15 of the word present in the cycle before enable was first sampled high.
- R8: Changing tp_use_word while enabled does not reset the bit position. On a return to the user word, transmission resumes at the bit the running position has reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tp_word | input | 16 | Programmable test word |
| tp_enable | input | 1 | 1 replaces normal data with the test source |
| tp_use_word | input | 1 | Source select: 1 user word, 0 static low level |
| nd_bit | input | 1 | Normal serial data bit |
| nd_valid | input | 1 | Normal data valid flag |
| tx_bit | output | 1 | Registered output bit |
| tx_valid | output | 1 | Registered output valid strobe |

## Verification
The bench builds the block with its default word width of 16. With this width, a 40-cycle enabled run covers more than two full wraps of the bit position. Word writes can then land at offsets well inside a word, where the R6 deferral is visible. The same width lets a source switch in the middle of a word exercise the R8 phase retention. A reference model in the bench tracks the position and the shadow word across enable toggles, so the R7 restart behaviour is compared on every cycle.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic {
    SRC_STATIC = 1'b0,
    SRC_WORD   = 1'b1
  } tpg_src_e;
endpackage

// File: rtl/tpg_rst_sync.sv
module tpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tpg_word_ser.sv
module tpg_word_ser #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [WORD_W-1:0] word_in,
  output logic              pat_bit
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WORD_W - 1);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] shd_q, shd_d;
  logic              at_last;
  logic              shd_en;

  always_comb begin
    at_last = (idx_q == '0);
    shd_en  = !run || at_last;
    shd_d   = word_in;
    if (!run || at_last) idx_d = IDX_TOP;
    else                 idx_d = idx_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= IDX_TOP;
      shd_q <= '0;
    end else begin
      idx_q <= idx_d;
      if (shd_en) shd_q <= shd_d;
    end
  end

  assign pat_bit = shd_q[idx_q];

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    run && (idx_q == '0) |=> idx_q == IDX_TOP); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && (idx_q != '0) |=> idx_q == $past(idx_q) - 1'b1); // R3
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run && (idx_q != '0) |=> $stable(shd_q)); // R6
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (idx_q == IDX_TOP) && (shd_q == $past(word_in))); // R7
endmodule

// File: rtl/tpg_out_stage.sv
module tpg_out_stage
  import tpg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  tpg_src_e src,
  input  logic     pat_bit,
  input  logic     nd_bit,
  input  logic     nd_valid,
  output logic     tx_bit,
  output logic     tx_valid
);
  logic bit_d, vld_d;

  always_comb begin
    if (en) begin
      vld_d = 1'b1;
      bit_d = (src == SRC_WORD) ? pat_bit : 1'b0;
    end else begin
      vld_d = nd_valid;
      bit_d = nd_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_bit   <= 1'b0;
      tx_valid <= 1'b0;
    end else begin
      tx_bit   <= bit_d;
      tx_valid <= vld_d;
    end
  end

  AST_VALID_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> tx_valid); // R2
  AST_STATIC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    en && (src == SRC_STATIC) |=> !tx_bit); // R4
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_bit == $past(nd_bit)) && (tx_valid == $past(nd_valid))); // R5
  AST_WORD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    en && (src == SRC_WORD) |=> tx_bit == $past(pat_bit)); // R3
endmodule

// File: rtl/fiber_tpg.sv
module fiber_tpg
  import tpg_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tp_word,
  input  logic              tp_enable,
  input  logic              tp_use_word,
  input  logic              nd_bit,
  input  logic              nd_valid,
  output logic              tx_bit,
  output logic              tx_valid
);
  logic     rst_int_n;
  logic     pat_bit;
  tpg_src_e src_sel;

  assign src_sel = tp_use_word ? SRC_WORD : SRC_STATIC;

  tpg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  tpg_word_ser #(.WORD_W(WORD_W)) u_ser (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (tp_enable),
    .word_in (tp_word),
    .pat_bit (pat_bit)
  );

  tpg_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (tp_enable),
    .src      (src_sel),
    .pat_bit  (pat_bit),
    .nd_bit   (nd_bit),
    .nd_valid (nd_valid),
    .tx_bit   (tx_bit),
    .tx_valid (tx_valid)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |-> !tx_bit && !tx_valid); // R1
endmodule

// File: tb/fiber_tpg_test.sv
module fiber_tpg_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] tp_word;
  logic         tp_enable, tp_use_word, nd_bit, nd_valid;
  logic         tx_bit, tx_valid;

  typedef struct {
    logic  b;
    logic  v;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   m_idx = W - 1;
  logic [W-1:0] m_shd = '0;
  bit   done = 0;

  always #4 clk = ~clk;

  fiber_tpg #(.WORD_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tp_word(tp_word), .tp_enable(tp_enable),
    .tp_use_word(tp_use_word), .nd_bit(nd_bit), .nd_valid(nd_valid),
    .tx_bit(tx_bit), .tx_valid(tx_valid)
  );

  task automatic check(input string tag, input logic ab, av, eb, ev);
    n_chk++;
    if (ab !== eb || av !== ev) begin
      n_fail++;
      $display("FAIL %s: bit/valid actual %b/%b expected %b/%b", tag, ab, av, eb, ev);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // driver: called at a negedge, applies inputs, pushes the expected output
  task automatic step(input string tag, input logic en, sel,
                      input logic [W-1:0] wd, input logic nb, nv);
    exp_t e;
    tp_enable = en; tp_use_word = sel; tp_word = wd; nd_bit = nb; nd_valid = nv;
    e.tag = tag;
    if (en) begin
      e.v = 1'b1;
      e.b = sel ? m_shd[m_idx] : 1'b0;
      if (m_idx == 0) begin m_idx = W - 1; m_shd = wd; end
      else m_idx--;
    end else begin
      e.v = nv; e.b = nb;
      m_idx = W - 1; m_shd = wd;
    end
    @(posedge clk);
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, tx_bit, tx_valid, e.b, e.v);
    end
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tp_word = '0; tp_enable = 0; tp_use_word = 0;
    nd_bit = 0; nd_valid = 0;
    #20;
    check("R1 in reset", tx_bit, tx_valid, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", tx_bit, tx_valid, 1'b0, 1'b0);
    // R5 pass-through
    for (int i = 0; i < 10; i++) step("R5 pass", 0, 1, 16'h0, i[0], i[1] | i[2]);
    // R3 / R2 continuous word
    for (int i = 0; i < 40; i++) step("R3 R2 word", 1, 1, 16'hA5C3, 0, 0);
    // R6 mid-word update
    for (int i = 0; i < 5; i++) step("R6 pre", 1, 1, 16'hA5C3, 0, 0);
    for (int i = 0; i < 36; i++) step("R6 change", 1, 1, 16'h1234, 0, 0);
    // R7 disable then re-enable with a new word
    for (int i = 0; i < 3; i++) step("R7 off", 0, 1, 16'hF00D, 1, 1);
    for (int i = 0; i < 20; i++) step("R7 restart", 1, 1, 16'hF00D, 1, 0);
    // R4 static level with changing word
    for (int i = 0; i < 20; i++) step("R4 static", 1, 0, 16'hFFFF ^ W'(i), 1, 1);
    // R8 select toggle mid-word
    for (int i = 0; i < 7; i++)  step("R8 word", 1, 1, 16'h8E71, 0, 0);
    for (int i = 0; i < 5; i++)  step("R8 static", 1, 0, 16'h8E71, 0, 0);
    for (int i = 0; i < 24; i++) step("R8 resume", 1, 1, 16'h8E71, 0, 0);
    for (int i = 0; i < 8; i++)  step("R5 back", 0, 0, 16'h0, ~i[0], 1);
    @(negedge clk);
    finish_run();
  end
endmodule